// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Status Logic

This block is the write-permission keeper of a serial EEPROM controller. It holds the write enable latch, the busy flag of the self-timed programming cycle, the protect-enable bit and the two block-protect bits. The serial front end hands it one decoded event per chip-select release. Each event carries the command code, a flag that says the release came exactly on a byte boundary after the full command, the target address, and, for a status write, the new status byte.

From these events and the write-protect pin the block decides whether an array write or a status write may go ahead. It starts the timed write cycle and presents the status byte that a status read returns. The array programming itself belongs to a neighbouring block. That block acts on the one-cycle `commitOk` pulse and may watch `busy`.

Top module: `nvm_write_guard`

## Requirements
- R1: After reset, `statusByte` is 8'h00, `busy` is 0 and `commitOk` is 0.
- R2: An event acts only when `csRise` and `cmdComplete` are both 1 in the same cycle. A `csRise` with `cmdComplete`=0 changes nothing. Command codes on `cmdOp` are: 1 = set latch, 2 = clear latch, 3 = array write, 4 = status write, 5 = read; any other code has no effect.
- R3: A set-latch event (code 1) sets the latch, seen as `statusByte` bit 1, in the cycle after the event edge.
- R4: A clear-latch event (code 2) clears the latch, whatever the protection and busy state.
- R5: An array write (code 3) with the latch set, not busy and to an unprotected address gives `commitOk`=1 for exactly one cycle after the event edge. It sets `statusByte` bit 0 and `busy`, and it clears the latch.
- R6: An array write with the latch clear is dropped: no `commitOk`, no busy cycle.
- R7: Protect bits {bit3,bit2} of the status byte guard address ranges, with `a` the two top address bits: 00 none, 01 guards a==11, 10 guards a[1]==1, 11 guards everything. A write into a guarded range is dropped and leaves the latch unchanged.
- R8: A status write (code 4) with the latch set and not busy loads bit 7 (protect enable) and bits 3..2 (protect select) from `statusIn`. It clears the latch and starts a busy cycle. Bits 6..4 always read 0.
- R9: When bit 7 is 1 and `wpN` is 0, a status write is dropped and the latch is kept. When bit 7 is 0, `wpN` has no effect.
- R10: After an accepted write, `busy` and `statusByte` bit 0 stay 1 for exactly `WRITE_CYCLES` clock cycles and then return to 0.
- R11: Set-latch, array-write and status-write events that arrive while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-up) |
| csRise | input | 1 | One-cycle pulse: chip select released |
| cmdComplete | input | 1 | Release came right after a whole command sequence |
| cmdOp | input | 3 | Decoded command code |
| cmdAddr | input | ADDR_W | Target array address of a write |
| statusIn | input | 8 | New status byte of a status write |
| wpN | input | 1 | Write-protect pin, active low |
| statusByte | output | 8 | Status byte {pen,0,0,0,bp1,bp0,latch,busy} |
| commitOk | output | 1 | One-cycle array-write go pulse |
| busy | output | 1 | Timed write cycle running |

## Verification
On every cycle, the assertions check four points. No write cycle starts while one is running. Every accepted write leaves the latch clear. The latch and busy flag rise only on a strobe from the control. The status bits hold still when no strobe is present. Only the bench scenarios can show the full decision outcomes. These cover the protection ranges for each protect setting, the write-protect pin gating, partial-byte releases, the length of the busy window and the exact status byte values.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_SETWE = 3'd1,
    OP_CLRWE = 3'd2,
    OP_WRARR = 3'd3,
    OP_WRSTS = 3'd4,
    OP_READ  = 3'd5
  } guardOp_e;

  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       loadStatus;
    logic       startCycle;
    logic       commitArr;
    logic [2:0] newProt;   // {pen, bp1, bp0}
  } guardStrb_t;

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              csRise,
  input  logic              cmdComplete,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        statusIn,
  input  logic              wpN,
  input  logic              welQ,
  input  logic              wipQ,
  input  logic              penQ,
  input  logic [1:0]        bpQ,
  output guardStrb_t        strb
);

  localparam int TOP = ADDR_W - 1;

  logic       evValid;
  logic [1:0] addrHi;
  logic       inGuard;
  logic       stsLocked;
  guardOp_e   op;

  assign op        = guardOp_e'(cmdOp);
  assign evValid   = csRise && cmdComplete;
  assign addrHi    = cmdAddr[TOP -: 2];
  assign stsLocked = penQ && !wpN;

  always_comb begin
    unique case (bpQ)
      2'b00:   inGuard = 1'b0;
      2'b01:   inGuard = (addrHi == 2'b11);
      2'b10:   inGuard = addrHi[1];
      default: inGuard = 1'b1;
    endcase
  end

  always_comb begin
    strb = '0;
    strb.newProt = {statusIn[7], statusIn[3:2]};
    if (evValid) begin
      case (op)
        OP_SETWE: strb.setWel = !wipQ;
        OP_CLRWE: strb.clrWel = 1'b1;
        OP_WRARR: begin
          if (!wipQ && welQ && !inGuard) begin
            strb.commitArr  = 1'b1;
            strb.startCycle = 1'b1;
            strb.clrWel     = 1'b1;
          end
        end
        OP_WRSTS: begin
          if (!wipQ && welQ && !stsLocked) begin
            strb.loadStatus = 1'b1;
            strb.startCycle = 1'b1;
            strb.clrWel     = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import nvm_guard_pkg::*;
#(
  parameter int WRITE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  guardStrb_t strb,
  output logic       welQ,
  output logic       wipQ,
  output logic       penQ,
  output logic [1:0] bpQ,
  output logic       commitQ
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cycCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ    <= 1'b0;
      wipQ    <= 1'b0;
      penQ    <= 1'b0;
      bpQ     <= 2'b00;
      cycCnt  <= '0;
      commitQ <= 1'b0;
    end else begin
      commitQ <= strb.commitArr;
      if (strb.clrWel)      welQ <= 1'b0;
      else if (strb.setWel) welQ <= 1'b1;
      if (strb.loadStatus) {penQ, bpQ} <= strb.newProt;
      if (strb.startCycle) begin
        wipQ   <= 1'b1;
        cycCnt <= CNT_LOAD;
      end else if (wipQ) begin
        if (cycCnt == '0) wipQ <= 1'b0;
        else              cycCnt <= cycCnt - 1'b1;
      end
    end
  end

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startCycle |-> !wipQ);

  // R5
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startCycle |=> !welQ);

  // R3
  latch_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(welQ) |-> $past(strb.setWel));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wipQ) |-> $past(strb.startCycle));

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setWel || strb.clrWel || strb.loadStatus) |=> $stable({penQ, bpQ, welQ}));

endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int WRITE_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csRise,
  input  logic              cmdComplete,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        statusIn,
  input  logic              wpN,
  output logic [7:0]        statusByte,
  output logic              commitOk,
  output logic              busy
);

  guardStrb_t strb;
  logic       welQ;
  logic       wipQ;
  logic       penQ;
  logic [1:0] bpQ;

  guard_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .csRise(csRise), .cmdComplete(cmdComplete), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .statusIn(statusIn), .wpN(wpN),
    .welQ(welQ), .wipQ(wipQ), .penQ(penQ), .bpQ(bpQ), .strb(strb)
  );

  guard_dp #(.WRITE_CYCLES(WRITE_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .welQ(welQ), .wipQ(wipQ), .penQ(penQ), .bpQ(bpQ), .commitQ(commitOk)
  );

  assign statusByte = {penQ, 3'b000, bpQ, welQ, wipQ};
  assign busy       = wipQ;

endmodule

// File: tb/tb_nvm_write_guard.sv
`timescale 1ns/1ps
module tb_nvm_write_guard;

  localparam int ADDR_W = 14;
  localparam int NCYC   = 20;
  localparam int NVEC   = 18;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              csRise = 1'b0;
  logic              cmdComplete = 1'b0;
  logic [2:0]        cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0]        statusIn = '0;
  logic              wpN = 1'b1;
  logic [7:0]        statusByte;
  logic              commitOk;
  logic              busy;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  nvm_write_guard #(.ADDR_W(ADDR_W), .WRITE_CYCLES(NCYC)) dut (
    .clk(clk), .rstN(rstN), .csRise(csRise), .cmdComplete(cmdComplete),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .statusIn(statusIn), .wpN(wpN),
    .statusByte(statusByte), .commitOk(commitOk), .busy(busy)
  );

  // {op[3], complete, addr[14], data[8], wpN, expStatus[8], expCommit}
  localparam logic [35:0] VEC [NVEC] = '{
    {3'd3, 1'b1, 14'h0100, 8'h00, 1'b1, 8'h00, 1'b0}, // R6 write without latch
    {3'd1, 1'b0, 14'h0000, 8'h00, 1'b1, 8'h00, 1'b0}, // R2 partial release
    {3'd1, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h02, 1'b0}, // R3 set latch
    {3'd2, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h00, 1'b0}, // R4 clear latch
    {3'd1, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h02, 1'b0}, // R3
    {3'd3, 1'b1, 14'h3FFF, 8'h00, 1'b1, 8'h01, 1'b1}, // R5 accepted write
    {3'd1, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h02, 1'b0}, // R3
    {3'd4, 1'b1, 14'h0000, 8'h84, 1'b1, 8'h85, 1'b0}, // R8 pen=1 bp=01
    {3'd1, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h86, 1'b0}, // R3
    {3'd3, 1'b1, 14'h3000, 8'h00, 1'b1, 8'h86, 1'b0}, // R7 top quarter guarded
    {3'd3, 1'b1, 14'h2FFF, 8'h00, 1'b1, 8'h85, 1'b1}, // R7 just below
    {3'd1, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h86, 1'b0}, // R3
    {3'd4, 1'b1, 14'h0000, 8'h08, 1'b0, 8'h86, 1'b0}, // R9 pin locks status
    {3'd4, 1'b1, 14'h0000, 8'hF8, 1'b1, 8'h89, 1'b0}, // R8 unused bits read 0
    {3'd1, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h8A, 1'b0}, // R3
    {3'd3, 1'b1, 14'h2000, 8'h00, 1'b1, 8'h8A, 1'b0}, // R7 upper half guarded
    {3'd3, 1'b1, 14'h1FFF, 8'h00, 1'b1, 8'h89, 1'b1}, // R7 lower half open
    {3'd5, 1'b1, 14'h0000, 8'h00, 1'b1, 8'h88, 1'b0}  // R2 read has no effect
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic sendCmd(input logic [2:0] op, input logic cpl, input logic [ADDR_W-1:0] a,
                         input logic [7:0] d, input logic w);
    @(negedge clk);
    cmdOp = op; cmdComplete = cpl; cmdAddr = a; statusIn = d; wpN = w; csRise = 1'b1;
    @(negedge clk);
    csRise = 1'b0; cmdComplete = 1'b0; wpN = 1'b1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * NCYC && busy; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int busyCnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", statusByte, 8'h00);
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 commit", {7'd0, commitOk}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [35:0] e;
      e = VEC[v];
      sendCmd(e[35:33], e[32], e[31:18], e[17:10], e[9]);
      check($sformatf("vec%0d status R2..R9", v), statusByte, e[8:1]);
      check($sformatf("vec%0d commit R5/R7", v), {7'd0, commitOk}, {7'd0, e[0]});
      @(negedge clk);
      check($sformatf("vec%0d commit one-shot R5", v), {7'd0, commitOk}, 8'h00);
      waitIdle();
    end

    // R10 busy window length; state now pen=1 bp=10
    sendCmd(3'd1, 1'b1, '0, 8'h00, 1'b1);
    sendCmd(3'd3, 1'b1, 14'h0000, 8'h00, 1'b1);
    busyCnt = 0;
    for (int i = 0; i < 3 * NCYC; i++) begin
      if (busy) busyCnt++;
      @(negedge clk);
    end
    check("R10 busy length", 8'(busyCnt), 8'(NCYC));
    check("R10 idle status", statusByte, 8'h88);

    // R11 commands ignored while busy
    sendCmd(3'd1, 1'b1, '0, 8'h00, 1'b1);
    sendCmd(3'd3, 1'b1, 14'h0000, 8'h00, 1'b1);
    check("R11 busy after write", statusByte, 8'h89);
    sendCmd(3'd1, 1'b1, '0, 8'h00, 1'b1);
    check("R11 latch set ignored", statusByte, 8'h89);
    sendCmd(3'd4, 1'b1, '0, 8'h00, 1'b1);
    check("R11 status write ignored", statusByte, 8'h89);
    waitIdle();
    check("R11 settings kept", statusByte, 8'h88);

    // R7 protect-all, R9 pin ignored with pen=0
    sendCmd(3'd1, 1'b1, '0, 8'h00, 1'b1);
    sendCmd(3'd4, 1'b1, '0, 8'h0C, 1'b1);
    check("R8 pen cleared bp=11", statusByte, 8'h0D);
    waitIdle();
    sendCmd(3'd1, 1'b1, '0, 8'h00, 1'b1);
    sendCmd(3'd3, 1'b1, 14'h0000, 8'h00, 1'b1);
    check("R7 all guarded", statusByte, 8'h0E);
    check("R7 no commit", {7'd0, commitOk}, 8'h00);
    sendCmd(3'd4, 1'b1, '0, 8'h00, 1'b0);
    check("R9 pin ignored when pen=0", statusByte, 8'h01);
    waitIdle();
    check("R9 final status", statusByte, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule